// File: doc/BRIEF.md
# Package Idle-State Resolver

This block watches the idle state that each of a parameterised number of cores is asking for and turns those requests into one package-level idle state. The package can only be as deep as its shallowest core. Shallow states (C0, C1, C1E) are resolved directly. The two deep states (C3, C6) are never entered on the cores' say-so alone. The block first raises a permission request to the platform, then waits for a grant that arrives while that request is already visible.

The resolved state is registered. A one-cycle strobe marks every cycle in which it takes a new value. A core waking to C0 pulls the package back to C0 on the next clock edge, whatever the grant is doing. Withdrawing the grant does the same.

The block only decides and sequences the state. Clock gating, voltage control, cache flushing and snoop handling are left to the logic that consumes its outputs.

Top module: `pidle_resolver`

## Requirements
- R1: Each core request is a 3-bit code, with core i at bits [3i+2:3i] of `core_req_i`. The codes are C0=0, C1=1, C1E=2, C3=3 and C6=4. Codes 5, 6 and 7 are treated as C6. `pkg_state_o` uses the same codes and is never above 4.
- R2: While `rst_n` is low, `pkg_state_o` is 0 (C0), and `perm_req_o` and `change_o` are 0.
- R3: When the shallowest core request is C0 or C1, `pkg_state_o` is C0 one cycle later.
- R4: When the shallowest core request is C1E, `pkg_state_o` is C1E (2) one cycle later. No grant is needed and `perm_req_o` is low.
- R5: When the shallowest core request is C3 or deeper, `perm_req_o` is high one cycle later. While no grant is present, the package stays in C0.
- R6: A deep package state is entered one cycle after a cycle in which `perm_req_o` was already high, `grant_i` is high and the shallowest request is still deep. The package state then equals that shallowest code. A grant seen while `perm_req_o` is low has no effect.
- R7: Package C6 is reached only when every core requests C6. A mix of C3 and C6 gives package C3.
- R8: Any core requesting C0 puts the package in C0 on the next cycle, even while the grant is high.
- R9: If the grant drops while the package is in a deep state, the package is in C0 one cycle later.
- R10: `change_o` is high for exactly the cycles in which `pkg_state_o` differs from its value on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_i | input | 3*NUM_CORES | Packed per-core idle-state requests |
| grant_i | input | 1 | Platform permission for deep package states |
| pkg_state_o | output | 3 | Resolved package idle state |
| change_o | output | 1 | One-cycle strobe on a package state change |
| perm_req_o | output | 1 | Request to the platform for deep-state permission |

## Verification
All three outputs are registered, so each result is due one clock edge after the inputs that cause it. The one exception is deep entry, which needs two edges: the first raises the permission request, and the second accepts the grant. The driver sets inputs just after a rising edge and queues the expected outputs, tagged with the cycle number at which they are due. The monitor samples on the falling edge and compares only the entries whose due cycle has arrived, so the extra edge of the grant handshake appears as its own queued step rather than as a looser sampling window.

// File: rtl/pidle_pkg.sv
package pidle_pkg;
  localparam int CODE_W = 3;
  typedef enum logic [CODE_W-1:0] {
    PS_C0  = 3'd0,
    PS_C1  = 3'd1,
    PS_C1E = 3'd2,
    PS_C3  = 3'd3,
    PS_C6  = 3'd4
  } cstate_e;
endpackage

// File: rtl/pidle_min.sv
// Shallowest request across all cores; out-of-range codes clamp to C6.
module pidle_min
  import pidle_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES*CODE_W-1:0] req_i,
  output logic [CODE_W-1:0]           min_o
);
  logic [CODE_W-1:0] chain [NUM_CORES+1];

  assign chain[0] = PS_C6;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [CODE_W-1:0] raw;
    logic [CODE_W-1:0] clamped;
    assign raw     = req_i[i*CODE_W +: CODE_W];
    assign clamped = (raw > PS_C6) ? PS_C6 : raw;
    assign chain[i+1] = (clamped < chain[i]) ? clamped : chain[i];
  end

  assign min_o = chain[NUM_CORES];
endmodule

// File: rtl/pidle_policy.sv
// Next-state decision from the shallowest request and the grant handshake.
module pidle_policy
  import pidle_pkg::*;
(
  input  logic [CODE_W-1:0] min_i,
  input  logic              perm_q_i,
  input  logic              grant_i,
  output logic [CODE_W-1:0] next_state_o,
  output logic              next_perm_o
);
  logic deep;
  assign deep = (min_i >= PS_C3);

  always_comb begin
    next_perm_o  = deep;
    next_state_o = PS_C0;
    if (min_i == PS_C1E) begin
      next_state_o = PS_C1E;
    end else if (deep && perm_q_i && grant_i) begin
      next_state_o = min_i;
    end
  end
endmodule

// File: rtl/pidle_resolver.sv
module pidle_resolver
  import pidle_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES*CODE_W-1:0] core_req_i,
  input  logic                        grant_i,
  output logic [CODE_W-1:0]           pkg_state_o,
  output logic                        change_o,
  output logic                        perm_req_o
);
  logic [CODE_W-1:0] min_req;
  logic [CODE_W-1:0] state_q, state_d;
  logic              perm_q, perm_d;
  logic              chg_q, chg_d;

  pidle_min #(.NUM_CORES(NUM_CORES)) u_min (
    .req_i (core_req_i),
    .min_o (min_req)
  );

  pidle_policy u_pol (
    .min_i        (min_req),
    .perm_q_i     (perm_q),
    .grant_i      (grant_i),
    .next_state_o (state_d),
    .next_perm_o  (perm_d)
  );

  always_comb begin
    chg_d = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_C0;
      perm_q  <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      perm_q  <= perm_d;
      chg_q   <= chg_d;
    end
  end

  assign pkg_state_o = state_q;
  assign perm_req_o  = perm_q;
  assign change_o    = chg_q;
endmodule

// File: rtl/pidle_resolver_chk.sv
module pidle_resolver_chk
  import pidle_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_CORES*CODE_W-1:0] core_req_i,
  input logic                        grant_i,
  input logic [CODE_W-1:0]           pkg_state_o,
  input logic                        change_o,
  input logic                        perm_req_o
);
  logic any_c0;
  always_comb begin
    any_c0 = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (core_req_i[i*CODE_W +: CODE_W] == PS_C0) any_c0 = 1'b1;
    end
  end

  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_state_o <= PS_C6);

  assert_deep_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state_o >= PS_C3) |-> ($past(perm_req_o) && $past(grant_i)));

  assert_deep_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !perm_req_o |-> (pkg_state_o < PS_C3));

  assert_wake_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_c0 |=> (pkg_state_o == PS_C0));

  assert_strobe_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |-> (pkg_state_o != $past(pkg_state_o)));

  assert_no_strobe_when_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !change_o |-> $stable(pkg_state_o));
endmodule

bind pidle_resolver pidle_resolver_chk #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/sim_pidle_resolver.sv
`timescale 1ns/1ps
module sim_pidle_resolver;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC*3-1:0] core_req_i = '0;
  logic          grant_i = 1'b0;
  logic [2:0]    pkg_state_o;
  logic          change_o;
  logic          perm_req_o;

  always #4 clk = ~clk;  // 125 MHz

  pidle_resolver #(.NUM_CORES(NC)) u0 (.*);

  typedef struct {
    int    due;
    logic [2:0] st;
    logic  perm;
    logic  chg;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  logic [2:0] m_state = 3'd0;
  logic       m_perm  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares only entries whose due cycle has come.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      total += 3;
      if (pkg_state_o !== e.st) begin
        bad++; $display("FAIL %s state act=%0d exp=%0d", e.tag, pkg_state_o, e.st);
      end
      if (perm_req_o !== e.perm) begin
        bad++; $display("FAIL %s perm act=%0b exp=%0b", e.tag, perm_req_o, e.perm);
      end
      if (change_o !== e.chg) begin
        bad++; $display("FAIL %s/R10 change act=%0b exp=%0b", e.tag, change_o, e.chg);
      end
    end
  end

  // Driver: applies one cycle of input and queues the expected outputs.
  task automatic step(input logic [2:0] c0, c1, c2, c3, input logic g, input string tag);
    logic [2:0] codes[NC];
    logic [2:0] mn;
    logic [2:0] nst;
    exp_t e;
    @(posedge clk); #1;
    codes = '{c0, c1, c2, c3};
    mn = 3'd4;
    for (int i = 0; i < NC; i++) begin
      logic [2:0] v;
      v = (codes[i] > 3'd4) ? 3'd4 : codes[i];  // R1 clamp
      if (v < mn) mn = v;
      core_req_i[i*3 +: 3] = codes[i];
    end
    grant_i = g;
    if (mn <= 3'd1) nst = 3'd0;
    else if (mn == 3'd2) nst = 3'd2;
    else nst = (m_perm && g) ? mn : 3'd0;
    e.due = cyc + 1;
    e.st = nst;
    e.perm = (mn >= 3'd3);
    e.chg = (nst != m_state);
    e.tag = tag;
    q.push_back(e);
    m_state = nst;
    m_perm = e.perm;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total += 3;  // R2 reset state
    if (pkg_state_o !== 3'd0) begin bad++; $display("FAIL R2 state act=%0d exp=0", pkg_state_o); end
    if (perm_req_o !== 1'b0) begin bad++; $display("FAIL R2 perm act=%0b exp=0", perm_req_o); end
    if (change_o !== 1'b0) begin bad++; $display("FAIL R2 change act=%0b exp=0", change_o); end
    @(posedge clk); #1 rst_n = 1'b1;

    step(0, 0, 0, 0, 0, "R3");
    step(1, 1, 1, 1, 0, "R3");
    step(2, 2, 2, 2, 0, "R4");
    step(2, 3, 4, 4, 1, "R4");
    step(3, 3, 3, 3, 0, "R5");
    step(3, 3, 3, 3, 0, "R5");
    step(3, 3, 3, 3, 1, "R6");
    step(3, 4, 4, 4, 1, "R7");
    step(4, 4, 4, 4, 1, "R7");
    step(4, 4, 4, 4, 0, "R9");
    step(4, 4, 4, 4, 1, "R6");
    step(4, 0, 4, 4, 1, "R8");
    step(4, 4, 4, 4, 1, "R6");
    step(1, 1, 1, 1, 1, "R3");
    step(4, 4, 4, 4, 1, "R6");   // grant before request is ignored
    step(4, 4, 4, 4, 1, "R6");
    step(7, 7, 7, 7, 1, "R1");
    step(3, 7, 5, 6, 1, "R1");
    step(5, 6, 6, 7, 1, "R1");
    step(0, 6, 6, 7, 1, "R8");
    step(2, 2, 2, 2, 1, "R4");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule